// File: doc/BRIEF.md
# Radix-4 Butterfly Stage with Pass-Ahead Block Scaling

This block is one pipelined radix-4 butterfly for a fixed-point complex FFT. Each valid beat it takes four complex samples and three complex twiddles. It rotates inputs 1 to 3 by their twiddles, forms the four radix-4 sums at a widened precision, and brings them back to the stage word width. The reduction is either a rounded divide by 8 or a plain saturating fit, with no shift.

The scaling choice for a pass is made from the results of the pass before it. A sticky flag records whether any scaled output component of the current pass reached a magnitude of one eighth of full scale. At the pass-end strobe that flag becomes the pending decision. The next pass-start strobe applies the decision and, when it selects a divide, adds one to the transform-wide exponent that goes with the final data. A transform-start strobe resets the exponent and forces the first pass to divide.

Top module: `bfly_r4_adapt`

## Requirements
- R1: Input lanes 1, 2 and 3 are multiplied by twiddles 1, 2 and 3. Data and twiddles are two's-complement fractions with W-1 and TW-1 fraction bits. Each complex product is rounded half away from zero to W bits and saturated to [-2^(W-1), 2^(W-1)-1]. Lane 0 is not rotated. Lane k occupies bits [k*W +: W] of the data ports. Twiddle k occupies bits [(k-1)*TW +: TW].
- R2: With y the rotated lanes, the outputs are X0 = y0+y1+y2+y3, X1 = y0-j*y1-y2+j*y3, X2 = y0-y1+y2-y3 and X3 = y0+j*y1-y2-j*y3.
- R3: In a dividing pass each full-precision sum is divided by 8 and rounded half away from zero, so 1.5 LSB becomes 2 and -1.5 LSB becomes -2.
- R4: In a non-dividing pass each sum is output unshifted, saturated to W bits.
- R5: out_valid rises exactly two cycles after an in_valid beat. A cycle with in_valid low produces no output beat and does not affect the scaling decision.
- R6: A pass that begins with, or after, a transform-start strobe always divides by 8, whatever the previous pass produced.
- R7: If any valid output component of a pass has magnitude at least 2^(W-4) (+256 or -256 when W=12), the next pass divides. Otherwise the next pass does not divide. A value of 255 or -255 does not trigger a divide.
- R8: The threshold flag is cleared at every pass start and sampled at pass end, so earlier passes have no influence.
- R9: scale_exp is cleared by transform start, increases by one at each pass start that selects a divide, holds otherwise, and saturates at its all-ones value.
- R10: After reset, out_valid is 0, scale_exp is 0 and scale_div is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfm_start | input | 1 | Transform start strobe |
| pass_start | input | 1 | Pass start strobe; applies the pending scale decision |
| pass_end | input | 1 | Pass end strobe; captures the threshold flag |
| in_valid | input | 1 | Input beat valid |
| in_re | input | 4*W | Real parts of the four input lanes |
| in_im | input | 4*W | Imaginary parts of the four input lanes |
| tw_re | input | 3*TW | Real parts of twiddles 1 to 3 |
| tw_im | input | 3*TW | Imaginary parts of twiddles 1 to 3 |
| out_valid | output | 1 | Output beat valid |
| out_re | output | 4*W | Real parts of the four results |
| out_im | output | 4*W | Imaginary parts of the four results |
| scale_div | output | 1 | Current pass divides by 8 |
| scale_exp | output | EXP_W | Divides applied so far in this transform |

## Verification
A wrong threshold flag does not show up in the pass that causes it. It appears one cycle after the following pass start, when scale_div takes the wrong value. From there every output of that pass is 8 times too large or too small, and scale_exp is off by one for the rest of the transform. Faults in the rounding or the butterfly signs appear on the very next output beat, two cycles after the input, but only on inputs that hit a rounding tie or exercise the lane concerned. That is why the bench drives tie values, saturating products and the two threshold boundary codes directly.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  // Wide working precision for rounding and saturation helpers
  localparam int ACC_W = 40;

  typedef logic signed [ACC_W-1:0] acc_t;

  // Scale controller flag set
  typedef struct packed {
    logic first;  // next pass is the first of a transform
    logic hit;    // sticky threshold flag for the running pass
    logic pend;   // decision captured at the last pass end
    logic div;    // divide applied to the running pass
  } sc_state_t;

  // Arithmetic right shift by sh with round half away from zero
  function automatic acc_t rnd_shr(input acc_t v, input int sh);
    acc_t half;
    half = acc_t'(1) <<< (sh - 1);
    if (v < 0) return (v + half - acc_t'(1)) >>> sh;
    return (v + half) >>> sh;
  endfunction

  // Clamp to the range of a w-bit two's-complement number
  function automatic acc_t sat_w(input acc_t v, input int w);
    acc_t hi;
    acc_t lo;
    hi = (acc_t'(1) <<< (w - 1)) - acc_t'(1);
    lo = -(acc_t'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/bfly_cmul.sv
module bfly_cmul #(
  parameter int W  = 12,
  parameter int TW = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0]  x_re,
  input  logic signed [W-1:0]  x_im,
  input  logic signed [TW-1:0] w_re,
  input  logic signed [TW-1:0] w_im,
  output logic signed [W-1:0]  y_re,
  output logic signed [W-1:0]  y_im
);
  localparam int PW = W + TW + 1;

  logic signed [PW-1:0] xr, xi, wr, wi;
  logic signed [PW-1:0] p_re, p_im;
  logic signed [W-1:0]  y_re_n, y_im_n;

  always_comb begin
    xr   = PW'(x_re);
    xi   = PW'(x_im);
    wr   = PW'(w_re);
    wi   = PW'(w_im);
    p_re = xr * wr - xi * wi;
    p_im = xr * wi + xi * wr;
    y_re_n = W'(bfly_pkg::sat_w(bfly_pkg::rnd_shr(bfly_pkg::acc_t'(p_re), TW - 1), W));
    y_im_n = W'(bfly_pkg::sat_w(bfly_pkg::rnd_shr(bfly_pkg::acc_t'(p_im), TW - 1), W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_re <= '0;
      y_im <= '0;
    end else if (en) begin
      y_re <= y_re_n;
      y_im <= y_im_n;
    end
  end

endmodule

// File: rtl/bfly_core.sv
module bfly_core #(
  parameter int W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic           div,
  input  logic [4*W-1:0] y_re,
  input  logic [4*W-1:0] y_im,
  output logic           out_vld,
  output logic [4*W-1:0] o_re,
  output logic [4*W-1:0] o_im,
  output logic           big
);
  localparam int SW  = W + 3;
  localparam int THR = 1 << (W - 4);

  logic signed [SW-1:0] a_re [4];
  logic signed [SW-1:0] a_im [4];
  logic signed [SW-1:0] s_re [4];
  logic signed [SW-1:0] s_im [4];
  logic signed [W-1:0]  r_re [4];
  logic signed [W-1:0]  r_im [4];
  logic [4*W-1:0]       o_re_n, o_im_n;
  logic                 big_n;

  function automatic logic signed [W-1:0] fit(input logic signed [SW-1:0] v, input logic d);
    if (d) return W'(bfly_pkg::rnd_shr(bfly_pkg::acc_t'(v), 3));
    return W'(bfly_pkg::sat_w(bfly_pkg::acc_t'(v), W));
  endfunction

  function automatic logic at_thr(input logic signed [W-1:0] v);
    return (v >= THR) || (v <= -THR);
  endfunction

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      a_re[k] = SW'($signed(y_re[k*W +: W]));
      a_im[k] = SW'($signed(y_im[k*W +: W]));
    end
    // radix-4 sums; -j*(a+jb) = b-ja, +j*(a+jb) = -b+ja
    s_re[0] = a_re[0] + a_re[1] + a_re[2] + a_re[3];
    s_im[0] = a_im[0] + a_im[1] + a_im[2] + a_im[3];
    s_re[1] = a_re[0] + a_im[1] - a_re[2] - a_im[3];
    s_im[1] = a_im[0] - a_re[1] - a_im[2] + a_re[3];
    s_re[2] = a_re[0] - a_re[1] + a_re[2] - a_re[3];
    s_im[2] = a_im[0] - a_im[1] + a_im[2] - a_im[3];
    s_re[3] = a_re[0] - a_im[1] - a_re[2] + a_im[3];
    s_im[3] = a_im[0] + a_re[1] - a_im[2] - a_re[3];
    big_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      r_re[k] = fit(s_re[k], div);
      r_im[k] = fit(s_im[k], div);
      big_n   = big_n | at_thr(r_re[k]) | at_thr(r_im[k]);
      o_re_n[k*W +: W] = r_re[k];
      o_im_n[k*W +: W] = r_im[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      big     <= 1'b0;
      o_re    <= '0;
      o_im    <= '0;
    end else begin
      out_vld <= in_vld;
      big     <= in_vld & big_n;
      if (in_vld) begin
        o_re <= o_re_n;
        o_im <= o_im_n;
      end
    end
  end

endmodule

// File: rtl/bfly_scale_ctl.sv
module bfly_scale_ctl #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfm_start,
  input  logic             pass_start,
  input  logic             pass_end,
  input  logic             res_vld,
  input  logic             res_big,
  output logic             div,
  output logic [EXP_W-1:0] exp_cnt
);
  bfly_pkg::sc_state_t st_q, st_n;
  logic [EXP_W-1:0]    exp_q, exp_n, exp_base;
  logic                hit_in, take;

  always_comb begin
    st_n     = st_q;
    exp_n    = exp_q;
    hit_in   = res_vld & res_big;
    take     = xfm_start | st_q.first | st_q.pend;
    exp_base = xfm_start ? '0 : exp_q;
    if (xfm_start) begin
      st_n.first = 1'b1;
      exp_n      = '0;
    end
    if (pass_start) begin
      st_n.div   = take;
      st_n.first = 1'b0;
      st_n.hit   = 1'b0;
      if (take && (exp_base != '1)) exp_n = exp_base + 1'b1;
      else                          exp_n = exp_base;
    end else begin
      st_n.hit = st_q.hit | hit_in;
    end
    if (pass_end) st_n.pend = st_q.hit | hit_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '{first: 1'b1, hit: 1'b0, pend: 1'b1, div: 1'b1};
      exp_q <= '0;
    end else begin
      st_q  <= st_n;
      exp_q <= exp_n;
    end
  end

  assign div     = st_q.div;
  assign exp_cnt = exp_q;

endmodule

// File: rtl/bfly_r4_adapt.sv
module bfly_r4_adapt #(
  parameter int W          = 12,
  parameter int TW         = 12,
  parameter int MAX_PASSES = 6,
  parameter int EXP_W      = $clog2(MAX_PASSES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfm_start,
  input  logic             pass_start,
  input  logic             pass_end,
  input  logic             in_valid,
  input  logic [4*W-1:0]   in_re,
  input  logic [4*W-1:0]   in_im,
  input  logic [3*TW-1:0]  tw_re,
  input  logic [3*TW-1:0]  tw_im,
  output logic             out_valid,
  output logic [4*W-1:0]   out_re,
  output logic [4*W-1:0]   out_im,
  output logic             scale_div,
  output logic [EXP_W-1:0] scale_exp
);
  localparam int LANES = 4;

  logic           v1_q;
  logic [4*W-1:0] y_re, y_im;
  logic           res_big;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v1_q <= 1'b0;
    else        v1_q <= in_valid;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [W-1:0] lane_re, lane_im;
    if (k == 0) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lane_re <= '0;
          lane_im <= '0;
        end else if (in_valid) begin
          lane_re <= $signed(in_re[W-1:0]);
          lane_im <= $signed(in_im[W-1:0]);
        end
      end
    end else begin : g_rot
      bfly_cmul #(.W(W), .TW(TW)) u_cmul (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (in_valid),
        .x_re ($signed(in_re[k*W +: W])),
        .x_im ($signed(in_im[k*W +: W])),
        .w_re ($signed(tw_re[(k-1)*TW +: TW])),
        .w_im ($signed(tw_im[(k-1)*TW +: TW])),
        .y_re (lane_re),
        .y_im (lane_im)
      );
    end
    assign y_re[k*W +: W] = lane_re;
    assign y_im[k*W +: W] = lane_im;
  end

  bfly_core #(.W(W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (v1_q),
    .div    (scale_div),
    .y_re   (y_re),
    .y_im   (y_im),
    .out_vld(out_valid),
    .o_re   (out_re),
    .o_im   (out_im),
    .big    (res_big)
  );

  bfly_scale_ctl #(.EXP_W(EXP_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfm_start (xfm_start),
    .pass_start(pass_start),
    .pass_end  (pass_end),
    .res_vld   (out_valid),
    .res_big   (res_big),
    .div       (scale_div),
    .exp_cnt   (scale_exp)
  );

endmodule

// File: rtl/bfly_r4_adapt_chk.sv
module bfly_r4_adapt_chk #(
  parameter int W     = 12,
  parameter int EXP_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xfm_start,
  input logic             pass_start,
  input logic             in_valid,
  input logic             out_valid,
  input logic [4*W-1:0]   out_re,
  input logic [4*W-1:0]   out_im,
  input logic             scale_div,
  input logic [EXP_W-1:0] scale_exp
);
  localparam int LIM = 1 << (W - 2);

  logic in_div_range;
  always_comb begin
    in_div_range = 1'b1;
    for (int k = 0; k < 4; k++) begin
      if ($signed(out_re[k*W +: W]) > LIM || $signed(out_re[k*W +: W]) < -LIM) in_div_range = 1'b0;
      if ($signed(out_im[k*W +: W]) > LIM || $signed(out_im[k*W +: W]) < -LIM) in_div_range = 1'b0;
    end
  end

  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  a_r5_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  a_r6_first_div: assert property (@(posedge clk) disable iff (!rst_n)
    (xfm_start && pass_start) |=> (scale_div && scale_exp == EXP_W'(1)));

  a_r8_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_start |=> $stable(scale_div));

  a_r9_exp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_start && !xfm_start) |=> $stable(scale_exp));

  a_r9_exp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_start && !xfm_start && scale_exp != '1) |=>
      (scale_div == (scale_exp != $past(scale_exp))));

  a_r3_div_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && scale_div) |-> in_div_range);

endmodule

bind bfly_r4_adapt bfly_r4_adapt_chk #(.W(W), .EXP_W(EXP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .xfm_start (xfm_start),
  .pass_start(pass_start),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_re    (out_re),
  .out_im    (out_im),
  .scale_div (scale_div),
  .scale_exp (scale_exp)
);

// File: tb/bfly_r4_adapt_bench.sv
module bfly_r4_adapt_bench;
  localparam int W  = 12;
  localparam int TW = 12;
  localparam int EW = 3;
  localparam int NV = 6;

  logic            clk = 1'b0;
  logic            rst_n, xfm_start, pass_start, pass_end, in_valid;
  logic [4*W-1:0]  in_re, in_im, out_re, out_im;
  logic [3*TW-1:0] tw_re, tw_im;
  logic            out_valid, scale_div;
  logic [EW-1:0]   scale_exp;

  int n_run  = 0;
  int n_fail = 0;
  int exp_re [4];
  int exp_im [4];

  always #5 clk = ~clk;

  bfly_r4_adapt #(.W(W), .TW(TW), .MAX_PASSES(6)) u_bfly_r4_adapt (
    .clk(clk), .rst_n(rst_n), .xfm_start(xfm_start), .pass_start(pass_start),
    .pass_end(pass_end), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .tw_re(tw_re), .tw_im(tw_im), .out_valid(out_valid), .out_re(out_re),
    .out_im(out_im), .scale_div(scale_div), .scale_exp(scale_exp)
  );

  // x0r x0i x1r x1i x2r x2i x3r x3i | w1r w1i w2r w2i w3r w3i
  localparam int STIM [NV][14] = '{
    '{ 2000, 0, 2000, 0, 2000, 0, 2000, 0,  2047, 0, 2047, 0, 2047, 0 },
    '{ 1000, -500, 300, 200, -700, 100, 50, -900,  1448, -1448, 0, -2048, -1448, -1448 },
    '{ -2048, -2048, 2047, 2047, -2048, 2047, 2047, -2048,  -2048, 0, 0, -2048, 1448, 1448 },
    '{ 13, -13, -5, 7, 19, -3, 11, 22,  2047, 0, -2048, 0, 0, 2047 },
    '{ -12, 12, 0, 0, 0, 0, 0, 0,  2047, 0, 2047, 0, 2047, 0 },
    '{ 123, -456, 789, -1011, -1213, 1415, 1617, -1819,  1448, -1448, -1448, 1448, 2047, -2048 }
  };

  function automatic int rnd_ref(input int v, input int sh);
    if (v >= 0) return (v + (1 << (sh - 1))) >>> sh;
    return -(((-v) + (1 << (sh - 1))) >>> sh);
  endfunction

  function automatic int sat_ref(input int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic int lane(input logic [4*W-1:0] v, input int k);
    return int'($signed(v[k*W +: W]));
  endfunction

  task automatic model(input int s[14], input bit dv);
    int yr[4];
    int yi[4];
    int sr[4];
    int si[4];
    yr[0] = s[0];
    yi[0] = s[1];
    for (int k = 1; k < 4; k++) begin
      yr[k] = sat_ref(rnd_ref(s[2*k] * s[6+2*k] - s[2*k+1] * s[7+2*k], 11));
      yi[k] = sat_ref(rnd_ref(s[2*k] * s[7+2*k] + s[2*k+1] * s[6+2*k], 11));
    end
    sr[0] = yr[0] + yr[1] + yr[2] + yr[3];
    si[0] = yi[0] + yi[1] + yi[2] + yi[3];
    sr[1] = yr[0] + yi[1] - yr[2] - yi[3];
    si[1] = yi[0] - yr[1] - yi[2] + yr[3];
    sr[2] = yr[0] - yr[1] + yr[2] - yr[3];
    si[2] = yi[0] - yi[1] + yi[2] - yi[3];
    sr[3] = yr[0] - yi[1] - yr[2] + yi[3];
    si[3] = yi[0] + yr[1] - yi[2] - yr[3];
    for (int k = 0; k < 4; k++) begin
      exp_re[k] = dv ? rnd_ref(sr[k], 3) : sat_ref(sr[k]);
      exp_im[k] = dv ? rnd_ref(si[k], 3) : sat_ref(si[k]);
    end
  endtask

  task automatic check(input string req, input string what, input int act, input int expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic drive(input int s[14], input bit vld);
    @(negedge clk);
    in_valid = vld;
    for (int k = 0; k < 4; k++) begin
      in_re[k*W +: W] = W'(s[2*k]);
      in_im[k*W +: W] = W'(s[2*k+1]);
    end
    for (int k = 0; k < 3; k++) begin
      tw_re[k*TW +: TW] = TW'(s[8+2*k]);
      tw_im[k*TW +: TW] = TW'(s[9+2*k]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  // One beat through the pipe, compared lane by lane with the model
  task automatic vec(input string req, input int s[14], input bit dv);
    int bad;
    model(s, dv);
    drive(s, 1'b1);
    bad = 0;
    n_run++;
    if (out_valid !== 1'b1) bad++;
    for (int k = 0; k < 4; k++) begin
      if (lane(out_re, k) != exp_re[k] || lane(out_im, k) != exp_im[k]) begin
        bad++;
        $display("FAIL %s lane %0d: actual (%0d,%0d) expected (%0d,%0d)", req, k,
                 lane(out_re, k), lane(out_im, k), exp_re[k], exp_im[k]);
      end
    end
    if (bad != 0) begin
      n_fail++;
      if (out_valid !== 1'b1) $display("FAIL %s out_valid: actual %0b expected 1", req, out_valid);
    end
  endtask

  function automatic void only_x0(output int s[14], input int xr, input int xi);
    for (int i = 0; i < 14; i++) s[i] = 0;
    s[0] = xr;
    s[1] = xi;
    s[8] = 2047; s[10] = 2047; s[12] = 2047;
  endfunction

  task automatic start_pass(input bit with_xfm);
    @(negedge clk);
    pass_start = 1'b1;
    xfm_start  = with_xfm;
    @(negedge clk);
    pass_start = 1'b0;
    xfm_start  = 1'b0;
  endtask

  task automatic end_pass();
    @(negedge clk);
    pass_end = 1'b1;
    @(negedge clk);
    pass_end = 1'b0;
  endtask

  task automatic expect_pass(input string req, input int dv, input int ex);
    check(req, "scale_div", int'(scale_div), dv);
    check(req, "scale_exp", int'(scale_exp), ex);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int s[14];
    int big[14];
    big = STIM[0];
    rst_n = 1'b0; xfm_start = 1'b0; pass_start = 1'b0; pass_end = 1'b0;
    in_valid = 1'b0; in_re = '0; in_im = '0; tw_re = '0; tw_im = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "out_valid", int'(out_valid), 0);
    expect_pass("R10", 1, 0);
    rst_n = 1'b1;

    // Pass A: transform start forces divide (R6), table in divide mode (R1 R2 R3)
    start_pass(1'b1);
    expect_pass("R6", 1, 1);
    for (int i = 0; i < NV; i++) vec("R1/R2/R3 table", STIM[i], 1'b1);
    end_pass();

    // Pass B: previous pass crossed threshold (R7); rounding ties (R3)
    start_pass(1'b0);
    expect_pass("R7", 1, 2);
    only_x0(s, -12, 0); vec("R3 neg tie", s, 1'b1);
    check("R3", "neg tie -1.5", lane(out_re, 2), -2);
    only_x0(s, 12, 0);  vec("R3 pos tie", s, 1'b1);
    check("R3", "pos tie 1.5", lane(out_re, 1), 2);
    only_x0(s, 2040, 0); vec("R7 below thr", s, 1'b1);
    check("R7", "scaled 255", lane(out_re, 3), 255);
    // R5 beats with in_valid low: no output, no flag
    drive(big, 1'b0);
    check("R5", "out_valid idle", int'(out_valid), 0);
    drive(big, 1'b0);
    end_pass();

    // Pass C: flag cleared at pass start, nothing big -> no divide (R8)
    start_pass(1'b0);
    expect_pass("R8", 0, 2);
    s = '{0, 0, -2048, 0, 0, 0, 0, 0, -2048, 0, 2047, 0, 2047, 0};
    vec("R1 product sat", s, 1'b0);
    check("R1", "X0 re sat product", lane(out_re, 0), 2047);
    check("R4", "X1 im unscaled", lane(out_im, 1), -2047);
    vec("R4 sum sat", big, 1'b0);
    check("R4", "X0 re sat sum", lane(out_re, 0), 2047);
    for (int i = 0; i < NV; i++) vec("R4 table", STIM[i], 1'b0);
    end_pass();

    // Pass D: divide, small only
    start_pass(1'b0);
    expect_pass("R7", 1, 3);
    only_x0(s, 2040, 0); vec("R7 small", s, 1'b1);
    end_pass();

    // Pass E: no divide; exactly +256 imaginary
    start_pass(1'b0);
    expect_pass("R7", 0, 3);
    only_x0(s, 0, 256); vec("R7 +256", s, 1'b0);
    check("R7", "X3 im 256", lane(out_im, 3), 256);
    end_pass();

    // Pass F: +256 triggers divide
    start_pass(1'b0);
    expect_pass("R7", 1, 4);
    only_x0(s, 8, 0); vec("R3 small", s, 1'b1);
    end_pass();

    // Pass G: -255 stays below threshold
    start_pass(1'b0);
    expect_pass("R7", 0, 4);
    only_x0(s, -255, 0); vec("R4 -255", s, 1'b0);
    end_pass();

    // Pass H: -256 reaches threshold
    start_pass(1'b0);
    expect_pass("R7", 0, 4);
    only_x0(s, -256, 0); vec("R4 -256", s, 1'b0);
    end_pass();

    // Pass I: divide; only invalid beats
    start_pass(1'b0);
    expect_pass("R7", 1, 5);
    drive(big, 1'b0);
    check("R5", "out_valid idle", int'(out_valid), 0);
    end_pass();

    // Pass J: invalid beats did not set the flag (R5)
    start_pass(1'b0);
    expect_pass("R5", 0, 5);
    vec("R4 big", big, 1'b0);
    end_pass();

    // Passes K, L, M: exponent climbs then saturates (R9)
    start_pass(1'b0);
    expect_pass("R9", 1, 6);
    vec("R3 big", big, 1'b1);
    end_pass();
    start_pass(1'b0);
    expect_pass("R9", 1, 7);
    vec("R3 big", big, 1'b1);
    end_pass();
    start_pass(1'b0);
    expect_pass("R9", 1, 7);
    only_x0(s, 8, 0); vec("R3 small", s, 1'b1);
    end_pass();

    // New transform: exponent clears, first pass divides despite small data (R6 R9)
    @(negedge clk);
    xfm_start = 1'b1;
    @(negedge clk);
    xfm_start = 1'b0;
    check("R9", "scale_exp after xfm", int'(scale_exp), 0);
    start_pass(1'b0);
    expect_pass("R6", 1, 1);

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule